// File: doc/BRIEF.md
# Outstanding Load Scoreboard

This block sits beside the issue stage of a single-issue 64-bit pipeline with 32 general registers. It tracks the memory loads that have been sent out but have not yet come back. Each cycle it sees the source and destination register indices of the instruction that wants to issue, and it decides whether that instruction must wait. Results of arithmetic instructions are forwarded, so they never hold anything up. A register that is still waiting for a load blocks every later instruction that reads it, and every later instruction that writes it.

Each issued load gets a small tag, and the tag remembers the destination register. Load data comes back with its tag, in any order. That return frees the tag, clears the waiting mark on its own register, and writes the data through a dedicated load write port. A separate port writes arithmetic results, so both kinds of result can be written in the same cycle. A touch load only warms the cache. It takes no tag, marks no register and never waits.

Top module: `load_scoreboard`

## Requirements
- R1: After a synchronous reset, no register is marked pending, all tags are free, `stall` is low with `issue_valid` low, and both write ports have their enables low.
- R2: `stall` is combinational on the issuing cycle. It is high when `issue_valid` is high, the kind is not touch, and a source marked used names a pending nonzero register. An unused source never stalls, and with `issue_valid` low `stall` is low.
- R3: Instruction kind encoding on `issue_kind`: 0 = ALU, 1 = load, 2 = touch, 3 = no destination. An ALU instruction that is accepted (`issue_valid` high, `stall` low) with a nonzero `dst` drives the ALU write port on the next cycle with `dst` and `alu_data`. A later reader of that register is not stalled.
- R4: Up to 4 loads may be outstanding. An accepted load takes the lowest-numbered free tag, shown on `issue_tag` in the issuing cycle, and marks `dst` pending.
- R5: A load issued while all 4 tags are in use stalls.
- R6: A return (`ret_valid` with a tag in use) frees that tag and clears only its register's pending mark, effective from the next cycle. On that next cycle it drives the load write port with the register and `ret_data`. Returns may come in any order.
- R7: A touch load never stalls, takes no tag and marks no register, even when all tags are busy or its sources are pending.
- R8: A load return and an accepted ALU instruction in the same cycle both appear on their write ports in the following cycle.
- R9: An ALU instruction or load whose nonzero `dst` is pending stalls until that load has returned.
- R10: Register 0 is never pending and never causes a stall. A load to register 0 takes a tag but produces no load write. An ALU instruction to register 0 produces no ALU write.
- R11: A return whose tag is not in use is ignored: there is no load write and no change to pending marks or tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction requests issue |
| issue_kind | input | 2 | 0 ALU, 1 load, 2 touch, 3 no destination |
| src_a | input | 5 | First source register index |
| src_a_used | input | 1 | First source is read |
| src_b | input | 5 | Second source register index |
| src_b_used | input | 1 | Second source is read |
| dst | input | 5 | Destination register index |
| alu_data | input | 64 | ALU result of the issuing instruction |
| stall | output | 1 | Hold the issuing instruction |
| issue_tag | output | 2 | Tag given to an accepted load |
| ret_valid | input | 1 | Load data returns this cycle |
| ret_tag | input | 2 | Tag of the returning load |
| ret_data | input | 64 | Returning load data |
| wb_alu_en | output | 1 | ALU write port enable |
| wb_alu_addr | output | 5 | ALU write port register |
| wb_alu_data | output | 64 | ALU write port data |
| wb_ld_en | output | 1 | Load write port enable |
| wb_ld_addr | output | 5 | Load write port register |
| wb_ld_data | output | 64 | Load write port data |

## Verification
Faults in this block show up in two ways. A pending mark that is set or cleared wrongly makes `stall` wrong in the issuing cycle, so the bench sweeps every register index as a source and as a destination after each change in the load state. A corrupted tag entry shows one cycle after a return, as a wrong address or a missing enable on the load write port. Tag exhaustion shows in the same cycle as a load that slips through, followed later by a wrong `issue_tag`.

// File: rtl/ldsb_pkg.sv
package ldsb_pkg;

    localparam int DEF_XLEN = 64;
    localparam int DEF_NREG = 32;
    localparam int DEF_NTAG = 4;

    typedef enum logic [1:0] {
        OP_ALU   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_TOUCH = 2'd2,
        OP_NONE  = 2'd3
    } op_kind_e;

    // kinds that claim a destination register
    function automatic logic claims_dst(op_kind_e k);
        return (k == OP_ALU) || (k == OP_LOAD);
    endfunction

    // kinds exempt from every hazard check
    function automatic logic hazard_exempt(op_kind_e k);
        return k == OP_TOUCH;
    endfunction

endpackage

// File: rtl/ldsb_pending.sv
module ldsb_pending #(
    parameter int NREG = ldsb_pkg::DEF_NREG,
    localparam int RW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [RW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [RW-1:0]   clr_idx,
    output logic [NREG-1:0] pend
);
    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_bit
            if (i == 0) begin : g_zero
                assign pend[i] = 1'b0;
            end else begin : g_live
                logic bit_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        bit_q <= 1'b0;
                    end else if (set_en && set_idx == RW'(i)) begin
                        bit_q <= 1'b1;
                    end else if (clr_en && clr_idx == RW'(i)) begin
                        bit_q <= 1'b0;
                    end
                end
                assign pend[i] = bit_q;
            end
        end
    endgenerate
endmodule

// File: rtl/ldsb_tags.sv
module ldsb_tags #(
    parameter int NTAG = ldsb_pkg::DEF_NTAG,
    parameter int RW   = 5,
    localparam int TW = (NTAG > 1) ? $clog2(NTAG) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc_en,
    input  logic [RW-1:0]   alloc_dst,
    input  logic            ret_valid,
    input  logic [TW-1:0]   ret_tag,
    output logic [TW-1:0]   free_tag,
    output logic            have_free,
    output logic            ret_hit,
    output logic [RW-1:0]   ret_dst,
    output logic [NTAG-1:0] live
);
    logic [RW-1:0] dst_q [NTAG];

    always_comb begin
        have_free = 1'b0;
        free_tag  = '0;
        for (int t = NTAG - 1; t >= 0; t--) begin
            if (!live[t]) begin
                have_free = 1'b1;
                free_tag  = TW'(t);
            end
        end
    end

    genvar t;
    generate
        for (t = 0; t < NTAG; t++) begin : g_tag
            logic live_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    live_q   <= 1'b0;
                    dst_q[t] <= '0;
                end else if (alloc_en && free_tag == TW'(t)) begin
                    live_q   <= 1'b1;
                    dst_q[t] <= alloc_dst;
                end else if (ret_valid && ret_tag == TW'(t)) begin
                    live_q   <= 1'b0;
                end
            end
            assign live[t] = live_q;
        end
    endgenerate

    assign ret_hit = ret_valid && live[ret_tag];
    assign ret_dst = dst_q[ret_tag];
endmodule

// File: rtl/ldsb_hazard.sv
module ldsb_hazard
    import ldsb_pkg::*;
#(
    parameter int NREG = DEF_NREG,
    localparam int RW = $clog2(NREG)
) (
    input  logic            issue_valid,
    input  op_kind_e        kind,
    input  logic [RW-1:0]   src_a,
    input  logic            src_a_used,
    input  logic [RW-1:0]   src_b,
    input  logic            src_b_used,
    input  logic [RW-1:0]   dst,
    input  logic [NREG-1:0] pend,
    input  logic            have_free,
    output logic            stall
);
    logic raw_a, raw_b, waw, no_tag;

    always_comb begin
        raw_a  = src_a_used && (src_a != '0) && pend[src_a];
        raw_b  = src_b_used && (src_b != '0) && pend[src_b];
        waw    = claims_dst(kind) && (dst != '0) && pend[dst];
        no_tag = (kind == OP_LOAD) && !have_free;
        stall  = issue_valid && !hazard_exempt(kind)
                 && (raw_a || raw_b || waw || no_tag);
    end
endmodule

// File: rtl/load_scoreboard.sv
module load_scoreboard
    import ldsb_pkg::*;
#(
    parameter int XLEN = DEF_XLEN,
    parameter int NREG = DEF_NREG,
    parameter int NTAG = DEF_NTAG,
    localparam int RW = $clog2(NREG),
    localparam int TW = (NTAG > 1) ? $clog2(NTAG) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_valid,
    input  logic [1:0]      issue_kind,
    input  logic [RW-1:0]   src_a,
    input  logic            src_a_used,
    input  logic [RW-1:0]   src_b,
    input  logic            src_b_used,
    input  logic [RW-1:0]   dst,
    input  logic [XLEN-1:0] alu_data,
    output logic            stall,
    output logic [TW-1:0]   issue_tag,
    input  logic            ret_valid,
    input  logic [TW-1:0]   ret_tag,
    input  logic [XLEN-1:0] ret_data,
    output logic            wb_alu_en,
    output logic [RW-1:0]   wb_alu_addr,
    output logic [XLEN-1:0] wb_alu_data,
    output logic            wb_ld_en,
    output logic [RW-1:0]   wb_ld_addr,
    output logic [XLEN-1:0] wb_ld_data
);
    typedef struct packed {
        logic            en;
        logic [RW-1:0]   addr;
        logic [XLEN-1:0] data;
    } wb_port_t;

    op_kind_e        kind;
    logic            accept, alloc_en, set_en;
    logic            have_free, ret_hit;
    logic [RW-1:0]   ret_dst;
    logic [NREG-1:0] pend_w;
    logic [NTAG-1:0] tag_live_w;
    wb_port_t        alu_q, ld_q;

    assign kind     = op_kind_e'(issue_kind);
    assign accept   = issue_valid && !stall;
    assign alloc_en = accept && (kind == OP_LOAD);
    assign set_en   = alloc_en && (dst != '0);

    ldsb_hazard #(.NREG(NREG)) u_hazard (
        .issue_valid (issue_valid),
        .kind        (kind),
        .src_a       (src_a),
        .src_a_used  (src_a_used),
        .src_b       (src_b),
        .src_b_used  (src_b_used),
        .dst         (dst),
        .pend        (pend_w),
        .have_free   (have_free),
        .stall       (stall)
    );

    ldsb_tags #(.NTAG(NTAG), .RW(RW)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (alloc_en),
        .alloc_dst (dst),
        .ret_valid (ret_valid),
        .ret_tag   (ret_tag),
        .free_tag  (issue_tag),
        .have_free (have_free),
        .ret_hit   (ret_hit),
        .ret_dst   (ret_dst),
        .live      (tag_live_w)
    );

    ldsb_pending #(.NREG(NREG)) u_pending (
        .clk     (clk),
        .rst     (rst),
        .set_en  (set_en),
        .set_idx (dst),
        .clr_en  (ret_hit),
        .clr_idx (ret_dst),
        .pend    (pend_w)
    );

    // write port for single-cycle results
    always_ff @(posedge clk) begin
        if (rst) begin
            alu_q <= '0;
        end else begin
            alu_q.en <= accept && (kind == OP_ALU) && (dst != '0);
            if (accept && kind == OP_ALU) begin
                alu_q.addr <= dst;
                alu_q.data <= alu_data;
            end
        end
    end

    // write port for returning loads
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_q <= '0;
        end else begin
            ld_q.en <= ret_hit && (ret_dst != '0);
            if (ret_hit) begin
                ld_q.addr <= ret_dst;
                ld_q.data <= ret_data;
            end
        end
    end

    assign wb_alu_en   = alu_q.en;
    assign wb_alu_addr = alu_q.addr;
    assign wb_alu_data = alu_q.data;
    assign wb_ld_en    = ld_q.en;
    assign wb_ld_addr  = ld_q.addr;
    assign wb_ld_data  = ld_q.data;
endmodule

// File: rtl/ldsb_checker.sv
module ldsb_checker #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    parameter int NTAG = 4,
    localparam int RW = $clog2(NREG),
    localparam int TW = (NTAG > 1) ? $clog2(NTAG) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic            issue_valid,
    input logic [1:0]      issue_kind,
    input logic [RW-1:0]   src_a,
    input logic            src_a_used,
    input logic            stall,
    input logic [NREG-1:0] pend,
    input logic [NTAG-1:0] live,
    input logic            ret_valid,
    input logic [TW-1:0]   ret_tag,
    input logic [XLEN-1:0] ret_data,
    input logic [XLEN-1:0] wb_ld_data
);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> !stall);

    assert_raw_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_kind != 2'd2 && src_a_used && src_a != '0 && pend[src_a])
        |-> stall);

    assert_touch_free_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_kind == 2'd2) |-> !stall);

    assert_tags_full_R5: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_kind == 2'd1 && (&live)) |-> stall);

    assert_ret_data_R6: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && live[ret_tag]) |=> (wb_ld_data == $past(ret_data)));

    assert_dead_ret_R11: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !live[ret_tag] && !issue_valid)
        |=> (live == $past(live) && pend == $past(pend)));
endmodule

bind load_scoreboard ldsb_checker #(.XLEN(XLEN), .NREG(NREG), .NTAG(NTAG)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_kind  (issue_kind),
    .src_a       (src_a),
    .src_a_used  (src_a_used),
    .stall       (stall),
    .pend        (pend_w),
    .live        (tag_live_w),
    .ret_valid   (ret_valid),
    .ret_tag     (ret_tag),
    .ret_data    (ret_data),
    .wb_ld_data  (wb_ld_data)
);

// File: tb/load_scoreboard_test.sv
module load_scoreboard_test;
    localparam logic [1:0] K_ALU = 2'd0, K_LD = 2'd1, K_TCH = 2'd2, K_NONE = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 0;
    logic [1:0]  issue_kind = 0;
    logic [4:0]  src_a = 0, src_b = 0, dst = 0;
    logic        src_a_used = 0, src_b_used = 0;
    logic [63:0] alu_data = 0, ret_data = 0;
    logic        ret_valid = 0;
    logic [1:0]  ret_tag = 0;
    logic        stall, wb_alu_en, wb_ld_en;
    logic [1:0]  issue_tag;
    logic [4:0]  wb_alu_addr, wb_ld_addr;
    logic [63:0] wb_alu_data, wb_ld_data;

    int nvec = 0, nbad = 0;
    bit finished = 0;

    // bench model of the load state
    bit       mpend [32];
    bit       mlive [4];
    bit [4:0] mdst  [4];

    always #5 clk = ~clk;

    load_scoreboard uut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_kind(issue_kind),
        .src_a(src_a), .src_a_used(src_a_used), .src_b(src_b), .src_b_used(src_b_used),
        .dst(dst), .alu_data(alu_data), .stall(stall), .issue_tag(issue_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_data(ret_data),
        .wb_alu_en(wb_alu_en), .wb_alu_addr(wb_alu_addr), .wb_alu_data(wb_alu_data),
        .wb_ld_en(wb_ld_en), .wb_ld_addr(wb_ld_addr), .wb_ld_data(wb_ld_data)
    );

    task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic bit lowest_free(output bit [1:0] t);
        for (int i = 3; i >= 0; i--) if (!mlive[i]) begin t = 2'(i); lowest_free = 1; end
    endfunction

    // one cycle: drive at the falling edge, check combinational outputs,
    // then the write ports just after the rising edge
    task automatic step(string rq, logic [1:0] k, logic [4:0] sa, bit ua,
                        logic [4:0] sb, bit ub, logic [4:0] d, logic [63:0] ad,
                        bit rv, logic [1:0] rt, logic [63:0] rd);
        bit       e_stall, acc, any_free, e_alu, e_ld;
        bit [1:0] ft;
        bit [4:0] e_ld_addr;
        issue_valid = 1; issue_kind = k; src_a = sa; src_a_used = ua;
        src_b = sb; src_b_used = ub; dst = d; alu_data = ad;
        ret_valid = rv; ret_tag = rt; ret_data = rd;
        #1;
        ft = 0; any_free = 0;
        for (int i = 3; i >= 0; i--) if (!mlive[i]) begin ft = 2'(i); any_free = 1; end
        e_stall = 0;
        if (k != K_TCH) begin
            if (ua && sa != 0 && mpend[sa]) e_stall = 1;
            if (ub && sb != 0 && mpend[sb]) e_stall = 1;
            if ((k == K_ALU || k == K_LD) && d != 0 && mpend[d]) e_stall = 1;
            if (k == K_LD && !any_free) e_stall = 1;
        end
        check(rq, "stall", 64'(stall), 64'(e_stall));
        acc = !e_stall;
        if (acc && k == K_LD) check(rq, "issue_tag", 64'(issue_tag), 64'(ft));
        e_alu = acc && k == K_ALU && d != 0;
        e_ld = rv && mlive[rt] && mdst[rt] != 0;
        e_ld_addr = mdst[rt];
        @(posedge clk);
        if (rv && mlive[rt]) begin mlive[rt] = 0; mpend[mdst[rt]] = 0; end
        if (acc && k == K_LD) begin
            mlive[ft] = 1; mdst[ft] = d;
            if (d != 0) mpend[d] = 1;
        end
        #1;
        check(rq, "wb_alu_en", 64'(wb_alu_en), 64'(e_alu));
        if (e_alu) begin
            check(rq, "wb_alu_addr", 64'(wb_alu_addr), 64'(d));
            check(rq, "wb_alu_data", wb_alu_data, ad);
        end
        check(rq, "wb_ld_en", 64'(wb_ld_en), 64'(e_ld));
        if (e_ld) begin
            check(rq, "wb_ld_addr", 64'(wb_ld_addr), 64'(e_ld_addr));
            check(rq, "wb_ld_data", wb_ld_data, rd);
        end
        @(negedge clk);
        issue_valid = 0; ret_valid = 0;
    endtask

    task automatic sweep_reads(string rq);
        for (int s = 0; s < 32; s++) step(rq, K_NONE, 5'(s), 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mpend[i] = 0;
        for (int i = 0; i < 4; i++) begin mlive[i] = 0; mdst[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state at the ports
        check("R1", "stall idle", 64'(stall), 0);
        check("R1", "wb_alu_en", 64'(wb_alu_en), 0);
        check("R1", "wb_ld_en", 64'(wb_ld_en), 0);
        @(negedge clk);
        sweep_reads("R1");

        // R3: ALU chains never stall and write one cycle later
        for (int r = 0; r < 32; r++)
            step("R3", K_ALU, 5'(r), 1, 5'(r), 1, 5'(r), 64'(r) * 64'h1003, 0, 0, 0);

        for (int g = 0; g < 8; g++) begin
            int base = (g < 7) ? 1 + 4 * g : 28;
            logic [4:0] spare = (base > 1) ? 5'(base - 1) : 5'd31;
            // R4: fill all tags
            for (int k = 0; k < 4; k++)
                step("R4", K_LD, 0, 0, 0, 0, 5'(base + k), 0, 0, 0, 0);
            // R5: no free tag
            step("R5", K_LD, 0, 0, 0, 0, spare, 0, 0, 0, 0);
            for (int s = 0; s < 32; s++) begin
                step("R2", K_NONE, 5'(s), 1, 0, 0, 0, 0, 0, 0, 0);
                step("R2", K_NONE, 0, 0, 5'(s), 1, 0, 0, 0, 0, 0);
                step("R2", K_NONE, 5'(s), 0, 5'(s), 0, 0, 0, 0, 0, 0);
                step("R9", K_ALU, 0, 0, 0, 0, 5'(s), 64'(s), 0, 0, 0);
                step("R7", K_TCH, 5'(s), 1, 5'(s), 1, 5'(s), 0, 0, 0, 0);
            end
            // R7: touch took no tag, so a load still stalls
            step("R7", K_LD, 0, 0, 0, 0, spare, 0, 0, 0, 0);
            // R6/R8: out-of-order returns alongside ALU retirement
            for (int j = 0; j < 4; j++) begin
                logic [1:0] t = (j == 0) ? 2'd2 : (j == 1) ? 2'd0 : (j == 2) ? 2'd3 : 2'd1;
                step("R8", K_ALU, 0, 0, 0, 0, spare, 64'hA5A5_0000 + 64'(g * 4 + j),
                     1, t, 64'hD00D_0000_0000 + 64'(g * 16 + j));
                // R11: same tag again is dead now
                step("R11", K_NONE, 0, 0, 0, 0, 0, 0, 1, t, 64'hBAD);
                sweep_reads("R6");
            end
        end

        // R10: register 0
        step("R10", K_LD, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R10", K_NONE, 0, 1, 0, 1, 0, 0, 0, 0, 0);
        step("R10", K_ALU, 0, 1, 0, 1, 0, 64'h77, 0, 0, 0);
        step("R10", K_LD, 0, 0, 0, 0, 0, 0, 1, 0, 64'h1234);
        step("R10", K_NONE, 0, 0, 0, 0, 0, 0, 1, 0, 64'h5678);
        step("R11", K_NONE, 0, 0, 0, 0, 0, 0, 1, 3, 64'h9);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nvec++; nbad++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule